// File: doc/BRIEF.md
# Narrow DMA Write Merger and Read Line Buffer

This block connects a narrow DMA requester to a 32-bit memory port. The requester makes 8-bit or 16-bit accesses. Narrow writes are collected in a single doubleword staging register with per-byte enables. The staging register goes to memory as one full-width write when all four bytes are present, or earlier when ordering requires it. Reads are served from a line buffer that holds one aligned line of `LINE_BEATS` doublewords (16 bytes by default). A miss loads the whole line with ascending beats. The buffer never fetches backward and never fetches ahead speculatively.

A four-state controller sequences the block:
- `ST_IDLE`: serves read hits in the same cycle.
- `ST_WACK`: acknowledges and merges a write.
- `ST_FLUSH`: drains the staging register.
- `ST_FILL`: loads a line.

The transitions are:
- `ST_IDLE` to `ST_WACK`: write with no conflict.
- `ST_IDLE` to `ST_FLUSH`: a write to another doubleword while one is staged, or a read that needs the staged bytes out first.
- `ST_IDLE` to `ST_FILL`: read miss with nothing staged.
- `ST_WACK` to `ST_FLUSH`: staging register now full.
- `ST_WACK` to `ST_IDLE`: staging register still partial.
- `ST_FLUSH` to `ST_IDLE`: memory accepted the write.
- `ST_FILL` to `ST_IDLE`: last beat accepted.

The requester holds `req_valid`, `req_write`, `req_word`, `req_addr` and `req_wdata` stable until it sees `req_ready` at a clock edge. The memory side holds `mem_req` and its qualifiers until `mem_ready`. On a read beat, `mem_rdata` is valid in the cycle where `mem_ready` is high.

Top module: `dlb_top`

## Requirements
- R1: Narrow writes to one doubleword are merged into a single memory write. When the merged enables reach 4'b1111, exactly one memory write with `mem_be`=4'b1111 carries all four written bytes. No memory write is ever issued with `mem_be`=0.
- R2: A write to a different doubleword while bytes are staged first issues a memory write of the staged doubleword with only its written enables set (for example 4'b0011 for a 16-bit write at offset 0).
- R3: A write with no staged conflict gets `req_ready` one cycle after `req_valid` is presented (one wait state). A write is never acknowledged in the first cycle of its request.
- R4: A read miss issues `LINE_BEATS` memory reads with `mem_be`=4'b1111, at `mem_addr` = line base + 4*k for k = 0, 1, 2, 3 in that order, and then returns the data.
- R5: A read that hits the buffered line, and does not touch a staged doubleword, gets `req_ready` in the same cycle as `req_valid` (zero wait states), with no memory access.
- R6: After a fill, no memory read is issued until the next miss (no prefetch). Reading below the buffered line is a miss.
- R7: A read to the doubleword currently staged first flushes it to memory and then returns the written data.
- R8: A write to a byte inside the buffered line updates the line, so a later hit returns the new byte without a memory read.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` hold their values.
- R10: After reset, `req_ready` and `mem_req` are low and the line buffer is empty, so the first read misses.
- R11: Lane mapping: `req_word`=0 selects the byte at `req_addr[1:0]` (memory bits 8*k+7:8*k). `req_word`=1 selects the 16-bit half chosen by `req_addr[1]`, which requires `req_addr[0]`=0. A byte read returns zeros in `req_rdata[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester access pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_ready | output | 1 | Access completes at this clock edge |
| req_rdata | output | 16 | Read data, valid with req_ready |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Doubleword-aligned memory address |
| mem_be | output | 4 | Byte enables, bit k = byte k |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A read hit answers combinationally, so the bench samples `req_ready` 8 ns after the falling edge where it drove the request and expects it there with zero counted waits. A conflict-free write is expected one falling edge later (exactly one wait). Flushes and fills follow the handshake and depend on the random `mem_ready`. The bench therefore waits until `mem_req` has been low at a falling edge before it compares memory-write and memory-read counts, enables and addresses. A monitor at each rising edge checks that memory qualifiers are held and that fill beats step upward.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WACK  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_FILL  = 2'd3
    } dlb_state_e;

    // byte enables touched by a narrow access
    function automatic logic [3:0] lane_mask(input logic is_word, input logic [1:0] off);
        if (is_word) lane_mask = off[1] ? 4'b1100 : 4'b0011;
        else         lane_mask = 4'b0001 << off;
    endfunction

    // replicate narrow write data across all lanes
    function automatic logic [31:0] lane_spread(input logic is_word, input logic [15:0] d);
        if (is_word) lane_spread = {d, d};
        else         lane_spread = {4{d[7:0]}};
    endfunction

    // extract narrow read data from a doubleword
    function automatic logic [15:0] lane_pick(input logic is_word, input logic [1:0] off,
                                              input logic [31:0] dw);
        logic [31:0] sh;
        sh = dw >> {off, 3'b000};
        if (is_word) lane_pick = off[1] ? dw[31:16] : dw[15:0];
        else         lane_pick = {8'h00, sh[7:0]};
    endfunction

endpackage

// File: rtl/dlb_wcomb.sv
module dlb_wcomb #(
    parameter int DWA_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             merge_en,
    input  logic [DWA_W-1:0] merge_dw,
    input  logic [3:0]       merge_be,
    input  logic [31:0]      merge_data,
    input  logic             drain,
    output logic             pend_valid,
    output logic [DWA_W-1:0] pend_dw,
    output logic [3:0]       pend_be,
    output logic [31:0]      pend_data,
    output logic             merged_full
);

    logic [3:0] base_be;

    assign base_be     = pend_valid ? pend_be : 4'b0000;
    assign merged_full = &(base_be | merge_be);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_dw    <= '0;
            pend_be    <= 4'b0000;
        end else if (drain) begin
            pend_valid <= 1'b0;
            pend_be    <= 4'b0000;
        end else if (merge_en) begin
            pend_valid <= 1'b1;
            pend_dw    <= merge_dw;
            pend_be    <= base_be | merge_be;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_data[8*g +: 8] <= 8'h00;
            else if (merge_en && merge_be[g])
                pend_data[8*g +: 8] <= merge_data[8*g +: 8];
        end
    end

endmodule

// File: rtl/dlb_linebuf.sv
module dlb_linebuf #(
    parameter int LINE_BEATS = 4,
    parameter int TAG_W      = 12,
    localparam int BEAT_W    = $clog2(LINE_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_we,
    input  logic              fill_last,
    input  logic [BEAT_W-1:0] fill_beat,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [31:0]       fill_data,
    input  logic              upd_en,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [BEAT_W-1:0] upd_beat,
    input  logic [3:0]        upd_be,
    input  logic [31:0]       upd_data,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [BEAT_W-1:0] look_beat,
    output logic              look_hit,
    output logic [31:0]       look_dw
);

    logic             line_valid;
    logic [TAG_W-1:0] line_tag;
    logic [31:0]      beat_q [LINE_BEATS];
    logic             upd_hit;

    assign upd_hit  = upd_en && line_valid && (line_tag == upd_tag);
    assign look_hit = line_valid && (line_tag == look_tag);
    assign look_dw  = beat_q[look_beat];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            line_tag   <= '0;
        end else if (fill_we) begin
            line_valid <= fill_last;
            if (fill_last) line_tag <= fill_tag;
        end
    end

    for (genvar b = 0; b < LINE_BEATS; b++) begin : g_beat
        for (genvar l = 0; l < 4; l++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    beat_q[b][8*l +: 8] <= 8'h00;
                else if (fill_we && fill_beat == BEAT_W'(b))
                    beat_q[b][8*l +: 8] <= fill_data[8*l +: 8];
                else if (upd_hit && upd_beat == BEAT_W'(b) && upd_be[l])
                    beat_q[b][8*l +: 8] <= upd_data[8*l +: 8];
            end
        end
    end

endmodule

// File: rtl/dlb_ctrl.sv
module dlb_ctrl
    import dlb_pkg::*;
#(
    parameter int LINE_BEATS = 4,
    localparam int BEAT_W    = $clog2(LINE_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              pend_valid,
    input  logic              same_dw,
    input  logic              line_hit,
    input  logic              merged_full,
    input  logic              mem_ready,
    output dlb_state_e        state,
    output logic [BEAT_W-1:0] beat,
    output logic              req_ready,
    output logic              merge_en,
    output logic              drain,
    output logic              fill_we,
    output logic              fill_last,
    output logic              mem_req,
    output logic              mem_we
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_BEATS - 1);

    dlb_state_e nxt;
    logic       rd_blocked;

    // a read must wait when staged bytes are its own doubleword, or when it misses
    assign rd_blocked = pend_valid && (same_dw || !line_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= nxt;
            if (state != ST_FILL)
                beat <= '0;
            else if (mem_ready)
                beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write)
                        nxt = (pend_valid && !same_dw) ? ST_FLUSH : ST_WACK;
                    else if (rd_blocked)
                        nxt = ST_FLUSH;
                    else if (!line_hit)
                        nxt = ST_FILL;
                end
            end
            ST_WACK:  nxt = merged_full ? ST_FLUSH : ST_IDLE;
            ST_FLUSH: if (mem_ready) nxt = ST_IDLE;
            ST_FILL:  if (mem_ready && beat == LAST_BEAT) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        merge_en  = 1'b0;
        drain     = 1'b0;
        fill_we   = 1'b0;
        fill_last = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = req_valid && !req_write && line_hit && !(pend_valid && same_dw);
            end
            ST_WACK: begin
                req_ready = 1'b1;
                merge_en  = 1'b1;
            end
            ST_FLUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                drain   = mem_ready;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                fill_we   = mem_ready;
                fill_last = mem_ready && (beat == LAST_BEAT);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dlb_top.sv
module dlb_top
    import dlb_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LINE_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic          req_ready,
    output logic [15:0]   req_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata
);

    localparam int BEAT_W = $clog2(LINE_BEATS);
    localparam int DWA_W  = AW - 2;
    localparam int TAG_W  = AW - 2 - BEAT_W;

    dlb_state_e        state;
    logic [BEAT_W-1:0] beat;
    logic [DWA_W-1:0]  req_dw;
    logic [TAG_W-1:0]  req_tag;
    logic [BEAT_W-1:0] req_beat;
    logic [3:0]        wr_be;
    logic [31:0]       wr_data;
    logic              merge_en, drain, fill_we, fill_last;
    logic              pend_valid, merged_full, line_hit, same_dw;
    logic [DWA_W-1:0]  pend_dw;
    logic [3:0]        pend_be;
    logic [31:0]       pend_data;
    logic [31:0]       look_dw;

    assign req_dw   = req_addr[AW-1:2];
    assign req_tag  = req_addr[AW-1:2+BEAT_W];
    assign req_beat = req_addr[2+BEAT_W-1:2];
    assign wr_be    = lane_mask(req_word, req_addr[1:0]);
    assign wr_data  = lane_spread(req_word, req_wdata);
    assign same_dw  = (pend_dw == req_dw);
    assign req_rdata = lane_pick(req_word, req_addr[1:0], look_dw);

    dlb_ctrl #(.LINE_BEATS(LINE_BEATS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .pend_valid  (pend_valid),
        .same_dw     (same_dw),
        .line_hit    (line_hit),
        .merged_full (merged_full),
        .mem_ready   (mem_ready),
        .state       (state),
        .beat        (beat),
        .req_ready   (req_ready),
        .merge_en    (merge_en),
        .drain       (drain),
        .fill_we     (fill_we),
        .fill_last   (fill_last),
        .mem_req     (mem_req),
        .mem_we      (mem_we)
    );

    dlb_wcomb #(.DWA_W(DWA_W)) u_wcomb (
        .clk         (clk),
        .rst_n       (rst_n),
        .merge_en    (merge_en),
        .merge_dw    (req_dw),
        .merge_be    (wr_be),
        .merge_data  (wr_data),
        .drain       (drain),
        .pend_valid  (pend_valid),
        .pend_dw     (pend_dw),
        .pend_be     (pend_be),
        .pend_data   (pend_data),
        .merged_full (merged_full)
    );

    dlb_linebuf #(.LINE_BEATS(LINE_BEATS), .TAG_W(TAG_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_we),
        .fill_last (fill_last),
        .fill_beat (beat),
        .fill_tag  (req_tag),
        .fill_data (mem_rdata),
        .upd_en    (merge_en),
        .upd_tag   (req_tag),
        .upd_beat  (req_beat),
        .upd_be    (wr_be),
        .upd_data  (wr_data),
        .look_tag  (req_tag),
        .look_beat (req_beat),
        .look_hit  (line_hit),
        .look_dw   (look_dw)
    );

    always_comb begin
        mem_addr  = '0;
        mem_be    = 4'b0000;
        mem_wdata = 32'h0;
        unique case (state)
            ST_FLUSH: begin
                mem_addr  = {pend_dw, 2'b00};
                mem_be    = pend_be;
                mem_wdata = pend_data;
            end
            ST_FILL: begin
                mem_addr = {req_tag, beat, 2'b00};
                mem_be   = 4'b1111;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dlb_chk.sv
module dlb_chk #(
    parameter int AW         = 16,
    parameter int LINE_BEATS = 4,
    localparam int BEAT_W    = $clog2(LINE_BEATS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic          mem_ready
);

    // R3
    write_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) && req_write |-> !req_ready);

    // R1
    flush_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'b0000);

    // R4
    fill_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_be == 4'b1111);

    // R4
    fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> mem_addr[BEAT_W+1:2] == '0);

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready && (mem_addr[BEAT_W+1:2] != BEAT_W'(LINE_BEATS - 1))
        |=> mem_req && !mem_we && (mem_addr[BEAT_W+1:2] == $past(mem_addr[BEAT_W+1:2]) + 1'b1));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                                  && $stable(mem_be) && $stable(mem_wdata));

endmodule

bind dlb_top dlb_chk #(.AW(AW), .LINE_BEATS(LINE_BEATS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sim_dlb_top.sv
module sim_dlb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ready;
    logic [15:0]   req_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic          mem_ready = 1'b0;
    logic [31:0]   mem_rdata;

    logic [31:0] mmem [256];
    logic [7:0]  rmem [1024];

    int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, rdy_pct = 70;
    logic [AW-1:0] last_waddr = '0, last_raddr = '0, hold_addr = '0;
    logic [3:0]    last_be = '0;
    logic [31:0]   last_wdata = '0;
    logic          hold_v = 1'b0;

    always #10 clk = ~clk;

    dlb_top #(.AW(AW), .LINE_BEATS(4)) u0 (.*);

    assign mem_rdata = mmem[mem_addr[9:2]];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) mem_ready = mem_req && (($urandom % 100) < rdy_pct);

    // memory model and port monitor
    always @(posedge clk) if (rst_n) begin
        if (hold_v) check(mem_req && mem_addr == hold_addr, "R9 held request", mem_addr, hold_addr);
        hold_v    = mem_req && !mem_ready;
        hold_addr = mem_addr;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mmem[mem_addr[9:2]][8*l +: 8] = mem_wdata[8*l +: 8];
                wr_cnt++;
                last_waddr = mem_addr;
                last_be    = mem_be;
                last_wdata = mem_wdata;
            end else begin
                if (mem_addr[3:2] != 2'd0)
                    check(mem_addr == last_raddr + 4, "R4 ascending beat", mem_addr, last_raddr + 4);
                rd_cnt++;
                last_raddr = mem_addr;
            end
        end
    end

    function automatic logic [15:0] exp_read(input bit wd, input logic [AW-1:0] a);
        if (wd) return {rmem[a[9:0] + 10'd1], rmem[a[9:0]]};
        return {8'h00, rmem[a[9:0]]};
    endfunction

    task automatic do_req(input bit wr, input bit wd, input logic [AW-1:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output int waits);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        waits = 0;
        #8;
        while (!req_ready && waits < 5000) begin
            waits++;
            @(negedge clk);
            #8;
        end
        if (waits >= 5000) check(1'b0, "R9 request stalled", 32'(waits), 32'd0);
        rd = req_rdata;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (wr) begin
            rmem[a[9:0]] = d[7:0];
            if (wd) rmem[a[9:0] + 10'd1] = d[15:8];
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (mem_req) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0]   rd;
        int            w, w0, r0, bad;
        logic [AW-1:0] lw_a;
        bit            lw_wd;
        void'($urandom(32'd2024));
        for (int b = 0; b < 1024; b++) begin
            rmem[b] = 8'(b * 7 + 3);
            mmem[b / 4][8 * (b % 4) +: 8] = 8'(b * 7 + 3);
        end
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check(!req_ready, "R10 ready low in reset", 32'(req_ready), 0);
        check(!mem_req, "R10 mem_req low in reset", 32'(mem_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3: four byte writes merge into one doubleword
        for (int k = 0; k < 4; k++) begin
            do_req(1, 0, AW'(16'h100 + k), 16'(8'h11 * (k + 1)), rd, w);
            check(w == 1, "R3 write one wait state", 32'(w), 1);
            if (k < 3) check(wr_cnt == 0, "R1 no early write", 32'(wr_cnt), 0);
        end
        settle();
        check(wr_cnt == 1, "R1 single merged write", 32'(wr_cnt), 1);
        check(last_be == 4'hF, "R1 full enables", 32'(last_be), 32'hF);
        check(last_wdata == 32'h44332211, "R1 merged data", last_wdata, 32'h44332211);
        check(last_waddr == 16'h100, "R1 write address", 32'(last_waddr), 32'h100);

        // R2: partial flush on write to another doubleword
        do_req(1, 1, 16'h104, 16'hBEEF, rd, w);
        do_req(1, 0, 16'h108, 16'h0077, rd, w);
        check(w > 1, "R2 write waits for flush", 32'(w), 2);
        check(wr_cnt == 2, "R2 flush count", 32'(wr_cnt), 2);
        check(last_be == 4'b0011, "R2 partial enables", 32'(last_be), 32'h3);
        check(last_waddr == 16'h104, "R2 flush address", 32'(last_waddr), 32'h104);

        // R4 / R10: first read misses and fills a whole line
        r0 = rd_cnt;
        do_req(0, 1, 16'h200, 0, rd, w);
        check(rd_cnt - r0 == 4, "R4 R10 four fill beats", 32'(rd_cnt - r0), 4);
        check(last_raddr == 16'h20C, "R4 last beat address", 32'(last_raddr), 32'h20C);
        check(rd == exp_read(1, 16'h200), "R4 miss data", 32'(rd), 32'(exp_read(1, 16'h200)));
        check(wr_cnt == 3, "R2 staged byte flushed before fill", 32'(wr_cnt), 3);

        // R5: hit with zero waits
        r0 = rd_cnt;
        do_req(0, 1, 16'h202, 0, rd, w);
        check(w == 0, "R5 zero wait hit", 32'(w), 0);
        check(rd == exp_read(1, 16'h202), "R5 hit data", 32'(rd), 32'(exp_read(1, 16'h202)));
        check(rd_cnt == r0, "R5 no memory access", 32'(rd_cnt), 32'(r0));

        // R6: no prefetch, descending read misses
        repeat (20) @(negedge clk);
        check(rd_cnt == r0, "R6 no prefetch", 32'(rd_cnt), 32'(r0));
        do_req(0, 0, 16'h1FF, 0, rd, w);
        check(rd_cnt - r0 == 4, "R6 descending read misses", 32'(rd_cnt - r0), 4);
        check(last_raddr == 16'h1FC, "R6 fill of lower line", 32'(last_raddr), 32'h1FC);
        check(rd == exp_read(0, 16'h1FF), "R11 byte read", 32'(rd), 32'(exp_read(0, 16'h1FF)));

        // R7 / R8: write into the buffered line, then read it back
        do_req(1, 0, 16'h1F1, 16'h00A5, rd, w);
        check(w == 1, "R3 write into line", 32'(w), 1);
        r0 = rd_cnt;
        w0 = wr_cnt;
        do_req(0, 1, 16'h1F6, 0, rd, w);
        check(w == 0, "R5 hit beside staged dword", 32'(w), 0);
        check(rd == exp_read(1, 16'h1F6), "R11 upper half", 32'(rd), 32'(exp_read(1, 16'h1F6)));
        do_req(0, 0, 16'h1F1, 0, rd, w);
        check(wr_cnt == w0 + 1, "R7 flush before read", 32'(wr_cnt), 32'(w0 + 1));
        check(rd == 16'h00A5, "R7 R11 written byte returned", 32'(rd), 32'h00A5);
        check(rd_cnt == r0, "R8 line updated without refill", 32'(rd_cnt), 32'(r0));

        // random mix
        rdy_pct = 50;
        lw_a  = 16'h1F1;
        lw_wd = 1'b0;
        for (int i = 0; i < 400; i++) begin
            bit            wr, wd;
            logic [AW-1:0] a;
            logic [15:0]   d;
            wr = 1'($urandom % 2);
            wd = 1'($urandom % 2);
            a  = AW'($urandom % 1024);
            if (wd) a[0] = 1'b0;
            d  = 16'($urandom);
            do_req(wr, wd, a, d, rd, w);
            if (wr) begin
                check(w >= 1, "R3 write never zero wait", 32'(w), 1);
                lw_a  = a;
                lw_wd = wd;
            end else begin
                check(rd == exp_read(wd, a), "R11 random read", 32'(rd), 32'(exp_read(wd, a)));
            end
        end

        // force the last staged doubleword out and compare memory image
        do_req(0, lw_wd, lw_a, 0, rd, w);
        check(rd == exp_read(lw_wd, lw_a), "R7 final read", 32'(rd), 32'(exp_read(lw_wd, lw_a)));
        settle();
        bad = 0;
        for (int b = 0; b < 1024; b++)
            if (mmem[b / 4][8 * (b % 4) +: 8] != rmem[b]) bad++;
        check(bad == 0, "R1 memory image", 32'(bad), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule